// File: doc/BRIEF.md
# Multicycle Controller with Posted Write

This block is the control unit of a small multicycle load/store processor, together with a compact datapath model: program counter, instruction register, operand latches, memory data register, ALU output register, register file and data memory. Register-file writes for loads and R-type instructions do not get a state of their own. On the cycle that leaves the last state of such an instruction, the controller latches the write enable, the destination select and the data-source select into flip-flops. The write then takes place during the fetch cycle of the following instruction.

During that fetch cycle, the write takes its data from the memory data register or the ALU output register, and its destination from the instruction register. All three still hold the previous instruction's values. A load therefore finishes in four cycles and an R-type instruction in three. Stores keep four cycles and branches keep three.

The bench supplies instructions combinationally from `pc_o` on `instr_i`. The posted write is visible on dedicated outputs. A combinational peek port reads any register.

Top module: `mpw_core`

## Requirements
- R1: A load (opcode bits [15:12] = 1, base register bits [11:9], target register bits [8:6], signed 6-bit offset bits [5:0]) takes exactly 4 cycles. It passes through state codes 0, 1, 2 and 3. The value it loads is data word number (base + sign-extended offset) mod 16.
- R2: An R-type instruction (opcode 0, source A bits [11:9], source B bits [8:6], destination bits [5:3], function bits [2:0]) takes exactly 3 cycles through state codes 0, 1 and 6. Its result is selected by the function code: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 unsigned less-than (1 or 0), 7 pass source A. All arithmetic is modulo 2^16.
- R3: A load or R-type instruction writes the register file during the fetch cycle of the next instruction. In that cycle `pw_we_o` is 1. `pw_addr_o` is the load's target field or the R-type's destination field. `pw_data_o` is the loaded word or the ALU result. The next instruction's operand read sees the new value.
- R4: The posted-write enable is reloaded on every cycle. It is 1 only in the single fetch cycle that directly follows state 3 or state 6, and it is 0 in every other cycle.
- R5: A store (opcode 2, same fields as a load) takes 4 cycles through state codes 0, 1, 2 and 5. It writes the source B register to data word (base + offset) mod 16. A branch-if-equal (opcode 3) takes 3 cycles through state codes 0, 1 and 8. When the two registers are equal, it moves the PC to PC+1+offset (mod 256). Neither of them asserts the posted write.
- R6: Register 0 always reads as zero. A posted write addressed to it is ignored.
- R7: Opcodes 4 to 15 take 2 cycles (state codes 0 and 1), change no register and no memory word, and post no write.
- R8: While reset is high and after it is released, the state is fetch (code 0), the PC is 0, the posted write is off, every register is zero and data word i holds 3*i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word at address `pc_o` |
| pc_o | output | 8 | Program counter |
| state_o | output | 4 | Controller state code |
| pw_we_o | output | 1 | Posted register write enable |
| pw_addr_o | output | 3 | Posted write destination register |
| pw_data_o | output | 16 | Posted write data |
| peek_addr_i | input | 3 | Register index for inspection |
| peek_data_o | output | 16 | Register contents at `peek_addr_i` |

## Verification
Each instruction's result shows up at one fixed point: the fetch cycle that begins the next instruction. In that cycle the bench checks the posted write's enable, address and data against an instruction-level model. It also checks the PC, for branch outcomes, and the number of cycles since the previous fetch, which is 4, 3, 4, 3 or 2 by opcode class. In every non-fetch cycle the posted enable must be 0. A store's effect and a write's commit are confirmed by the next load or operand read that depends on them. After the program settles into a self-loop, all registers are read through the peek port.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

    localparam int DATA_W  = 16;
    localparam int RADDR_W = 3;
    localparam int IMM_W   = 6;
    localparam int OP_W    = 4;

    localparam logic [OP_W-1:0] OPC_RTYPE = 4'd0;
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OP_W-1:0] OPC_BEQ   = 4'd3;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MADDR  = 4'd2,
        ST_MREAD  = 4'd3,
        ST_MWRITE = 4'd5,
        ST_EXEC   = 4'd6,
        ST_BRANCH = 4'd8
    } state_e;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [RADDR_W-1:0] rs;
        logic [RADDR_W-1:0] rt;
        logic [RADDR_W-1:0] rd;
        logic [2:0]         fn;
    } instr_t;

    typedef enum logic [1:0] {
        ASEL_TARGET = 2'd0,
        ASEL_ADDR   = 2'd1,
        ASEL_ROP    = 2'd2
    } alu_src_e;

    typedef struct packed {
        logic     ir_load;
        logic     pc_inc;
        logic     ab_load;
        logic     alu_load;
        alu_src_e alu_src;
        logic     mdr_load;
        logic     mem_write;
        logic     branch_chk;
    } ctrl_t;

    function automatic word_t sext_imm(input logic [IMM_W-1:0] imm);
        return {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic word_t alu_eval(input logic [2:0] fn, input word_t a, input word_t b);
        word_t r;
        case (fn)
            3'd0:    r = a + b;
            3'd1:    r = a - b;
            3'd2:    r = a & b;
            3'd3:    r = a | b;
            3'd4:    r = a ^ b;
            3'd5:    r = ~(a | b);
            3'd6:    r = (a < b) ? word_t'(1) : '0;
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic word_t dmem_seed(input int idx);
        return word_t'(idx * 3 + 1);
    endfunction

endpackage

// File: rtl/mpw_ctrl.sv
module mpw_ctrl
    import mpw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output state_e          state,
    output ctrl_t           ctrl,
    output logic            pw_we,
    output logic            pw_regdst,
    output logic            pw_mem2reg
);

    state_e nxt;

    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_MADDR;
                else if (opcode == OPC_RTYPE)                  nxt = ST_EXEC;
                else if (opcode == OPC_BEQ)                    nxt = ST_BRANCH;
                else                                           nxt = ST_FETCH;
            end
            ST_MADDR:  nxt = (opcode == OPC_LOAD) ? ST_MREAD : ST_MWRITE;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    // Write controls captured on the cycle leaving the last state of a
    // load or R-type; reloaded every cycle so nothing lingers.
    always_ff @(posedge clk) begin
        if (rst) begin
            pw_we      <= 1'b0;
            pw_regdst  <= 1'b0;
            pw_mem2reg <= 1'b0;
        end else begin
            pw_we      <= (state == ST_MREAD) || (state == ST_EXEC);
            pw_regdst  <= (state == ST_EXEC);
            pw_mem2reg <= (state == ST_MREAD);
        end
    end

    always_comb begin
        ctrl = '0;
        case (state)
            ST_FETCH: begin
                ctrl.ir_load = 1'b1;
                ctrl.pc_inc  = 1'b1;
            end
            ST_DECODE: begin
                ctrl.ab_load  = 1'b1;
                ctrl.alu_load = 1'b1;
                ctrl.alu_src  = ASEL_TARGET;
            end
            ST_MADDR: begin
                ctrl.alu_load = 1'b1;
                ctrl.alu_src  = ASEL_ADDR;
            end
            ST_MREAD:  ctrl.mdr_load  = 1'b1;
            ST_MWRITE: ctrl.mem_write = 1'b1;
            ST_EXEC: begin
                ctrl.alu_load = 1'b1;
                ctrl.alu_src  = ASEL_ROP;
            end
            ST_BRANCH: ctrl.branch_chk = 1'b1;
            default:   ctrl = '0;
        endcase
    end

    a_r4_pw_fetch_only: assert property (@(posedge clk) disable iff (rst)
        pw_we |-> state == ST_FETCH);

    a_r4_pw_follows_last: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MREAD || state == ST_EXEC) |=> pw_we);

    a_r5_no_pw_sw_beq: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MWRITE || state == ST_BRANCH) |=> !pw_we);

    a_r1_load_posts_mdr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MREAD) |=> (state == ST_FETCH && pw_mem2reg && !pw_regdst));

    a_r2_rtype_posts_alu: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_FETCH && pw_regdst && !pw_mem2reg));

    a_r7_bad_op_returns: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && opcode > OPC_BEQ) |=> (state == ST_FETCH));

endmodule

// File: rtl/mpw_regfile.sv
module mpw_regfile
    import mpw_pkg::*;
#(
    parameter int AW = RADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] ra1,
    output word_t         rd1,
    input  logic [AW-1:0] ra2,
    output word_t         rd2,
    input  logic [AW-1:0] ra3,
    output word_t         rd3
);

    localparam int NREGS = 1 << AW;

    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

    a_r6_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> rd1 == '0);

endmodule

// File: rtl/mpw_dmem.sv
module mpw_dmem
    import mpw_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata
);

    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= dmem_seed(i);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/mpw_core.sv
module mpw_core
    import mpw_pkg::*;
#(
    parameter int PC_W    = 8,
    parameter int DMEM_AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        instr_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [3:0]         state_o,
    output logic               pw_we_o,
    output logic [RADDR_W-1:0] pw_addr_o,
    output logic [DATA_W-1:0]  pw_data_o,
    input  logic [RADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0]  peek_data_o
);

    localparam int PC_PAD = DATA_W - PC_W;

    state_e    state;
    ctrl_t     ctrl;
    logic      pw_we, pw_regdst, pw_mem2reg;

    logic [PC_W-1:0] pc;
    instr_t          ir;
    word_t           a_q, b_q, mdr, aluout;
    word_t           rf_a, rf_b, alu_res, dm_rdata, wb_data;
    logic [RADDR_W-1:0] wb_addr;
    logic [IMM_W-1:0]   imm;

    assign imm = {ir.rd, ir.fn};

    mpw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opcode     (ir.op),
        .state      (state),
        .ctrl       (ctrl),
        .pw_we      (pw_we),
        .pw_regdst  (pw_regdst),
        .pw_mem2reg (pw_mem2reg)
    );

    // Posted write: destination and data come from registers that still
    // hold the previous instruction during this fetch.
    assign wb_addr = pw_regdst  ? ir.rd : ir.rt;
    assign wb_data = pw_mem2reg ? mdr   : aluout;

    mpw_regfile #(.AW(RADDR_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (pw_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (ir.rs),
        .rd1   (rf_a),
        .ra2   (ir.rt),
        .rd2   (rf_b),
        .ra3   (peek_addr_i),
        .rd3   (peek_data_o)
    );

    mpw_dmem #(.AW(DMEM_AW)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.mem_write),
        .addr  (aluout[DMEM_AW-1:0]),
        .wdata (b_q),
        .rdata (dm_rdata)
    );

    always_comb begin
        case (ctrl.alu_src)
            ASEL_TARGET: alu_res = {{PC_PAD{1'b0}}, pc} + sext_imm(imm);
            ASEL_ADDR:   alu_res = a_q + sext_imm(imm);
            ASEL_ROP:    alu_res = alu_eval(ir.fn, a_q, b_q);
            default:     alu_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            a_q    <= '0;
            b_q    <= '0;
            mdr    <= '0;
            aluout <= '0;
        end else begin
            if (ctrl.ir_load) ir <= instr_t'(instr_i);
            if (ctrl.pc_inc)
                pc <= pc + PC_W'(1);
            else if (ctrl.branch_chk && a_q == b_q)
                pc <= aluout[PC_W-1:0];
            if (ctrl.ab_load) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (ctrl.alu_load) aluout <= alu_res;
            if (ctrl.mdr_load) mdr    <= dm_rdata;
        end
    end

    assign pc_o      = pc;
    assign state_o   = state;
    assign pw_we_o   = pw_we;
    assign pw_addr_o = wb_addr;
    assign pw_data_o = wb_data;

    a_r5_beq_target: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BRANCH && a_q == b_q) |=> pc == $past(aluout[PC_W-1:0]));

    a_r5_beq_falls_through: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BRANCH && a_q != b_q) |=> $stable(pc));

    a_r3_ir_held_during_post: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MREAD || state == ST_EXEC) |=> $stable(ir));

endmodule

// File: tb/mpw_core_tb.sv
`timescale 1ns/1ps
module mpw_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i;
    logic [7:0]  pc_o;
    logic [3:0]  state_o;
    logic        pw_we_o;
    logic [2:0]  pw_addr_o;
    logic [15:0] pw_data_o;
    logic [2:0]  peek_addr_i = '0;
    logic [15:0] peek_data_o;

    always #2.5 clk = ~clk;

    logic [15:0] imem [64];
    assign instr_i = imem[pc_o[5:0]];

    mpw_core u_dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .pc_o(pc_o), .state_o(state_o),
        .pw_we_o(pw_we_o), .pw_addr_o(pw_addr_o), .pw_data_o(pw_data_o),
        .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc_r(input int fn, input int rs, input int rt, input int rd);
        return {4'd0, 3'(rs), 3'(rt), 3'(rd), 3'(fn)};
    endfunction

    function automatic logic [15:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {4'(op), 3'(rs), 3'(rt), 6'(imm)};
    endfunction

    // instruction-level reference model
    logic [15:0] mreg [8];
    logic [15:0] mdm  [16];
    int  mpc, exp_cyc, exp_addr, cyc, nfetch;
    logic [15:0] exp_data;
    bit  exp_we, have_prev, run, done;
    string cyc_tag;

    initial begin
        int n;
        n = 0;
        for (int k = 1; k < 8; k++) begin imem[n] = enc_i(1, 0, k, k); n++; end
        for (int f = 0; f < 8; f++) begin
            imem[n] = enc_r(f, (f*3+1)%8, (f*5+2)%8, (f+3)%8); n++;
        end
        imem[n] = enc_r(0, 2, 1, 2);  n++;   // dependent R chain
        imem[n] = enc_i(1, 2, 3, 0);  n++;   // load via freshly written r2
        imem[n] = enc_r(0, 3, 3, 4);  n++;   // uses load result immediately
        imem[n] = enc_i(2, 0, 4, 9);  n++;   // store r4 -> word 9
        imem[n] = enc_i(1, 0, 5, 9);  n++;   // load it back
        imem[n] = enc_i(7, 1, 2, 5);  n++;   // undefined opcode
        imem[n] = enc_i(3, 1, 1, 2);  n++;   // taken branch skips two
        imem[n] = enc_r(0, 7, 7, 1);  n++;
        imem[n] = enc_r(1, 7, 6, 2);  n++;
        imem[n] = enc_i(3, 1, 2, 1);  n++;   // branch on unequal
        imem[n] = enc_r(4, 5, 1, 6);  n++;
        imem[n] = enc_i(2, 3, 5, 6'h3F); n++; // negative offset store
        imem[n] = enc_i(1, 3, 6, 6'h3F); n++;
        imem[n] = enc_i(9, 0, 0, 0);  n++;   // undefined opcode
        imem[n] = enc_i(3, 0, 0, 6'h3F); n++; // self loop
        for (int i = n; i < 64; i++) imem[i] = enc_i(3, 0, 0, 6'h3F);
        for (int i = 0; i < 8; i++)  mreg[i] = '0;
        for (int i = 0; i < 16; i++) mdm[i] = 16'(i*3+1);
        mpc = 0; cyc = 0; nfetch = 0; have_prev = 0; run = 0; done = 0;
        exp_we = 0; exp_addr = 0; exp_data = '0; exp_cyc = 0;
    end

    always @(negedge clk) begin
        if (run && !done) begin
            if (state_o == 4'd0) begin
                if (have_prev) check(cyc == exp_cyc, cyc_tag, cyc, exp_cyc);
                check(pw_we_o == exp_we, "R3/R4 posted enable in fetch", pw_we_o, exp_we);
                if (exp_we) begin
                    check(pw_addr_o == exp_addr[2:0], "R3 posted address", pw_addr_o, exp_addr);
                    check(pw_data_o == exp_data, "R3 posted data", pw_data_o, exp_data);
                    if (exp_addr != 0) mreg[exp_addr] = exp_data;
                end
                check(pc_o == mpc[7:0], "R5 fetch address", pc_o, mpc);
                begin
                    logic [15:0] ins, va, vb, imm, res;
                    int op, rs, rt, rd, fn;
                    ins = imem[mpc[5:0]];
                    op = ins[15:12]; rs = ins[11:9]; rt = ins[8:6]; rd = ins[5:3]; fn = ins[2:0];
                    imm = {{10{ins[5]}}, ins[5:0]};
                    va = mreg[rs]; vb = mreg[rt];
                    mpc = (mpc + 1) & 255;
                    exp_we = 0;
                    case (op)
                        0: begin
                            case (fn)
                                0: res = va + vb;
                                1: res = va - vb;
                                2: res = va & vb;
                                3: res = va | vb;
                                4: res = va ^ vb;
                                5: res = ~(va | vb);
                                6: res = (va < vb) ? 16'd1 : 16'd0;
                                default: res = va;
                            endcase
                            exp_cyc = 3; exp_we = 1; exp_addr = rd; exp_data = res;
                            cyc_tag = "R2 R-type cycle count";
                        end
                        1: begin
                            exp_cyc = 4; exp_we = 1; exp_addr = rt;
                            exp_data = mdm[4'(va + imm)];
                            cyc_tag = "R1 load cycle count";
                        end
                        2: begin
                            exp_cyc = 4; mdm[4'(va + imm)] = vb;
                            cyc_tag = "R5 store cycle count";
                        end
                        3: begin
                            exp_cyc = 3;
                            if (va == vb) mpc = (mpc + int'($signed(imm))) & 255;
                            cyc_tag = "R5 branch cycle count";
                        end
                        default: begin
                            exp_cyc = 2;
                            cyc_tag = "R7 undefined opcode cycle count";
                        end
                    endcase
                end
                have_prev = 1;
                cyc = 1;
                nfetch++;
                if (nfetch >= 140) done = 1;
            end else begin
                cyc++;
                check(pw_we_o == 1'b0, "R4 posted enable outside fetch", pw_we_o, 0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(state_o == 4'd0, "R8 reset state", state_o, 0);
        check(pc_o == 8'd0, "R8 reset pc", pc_o, 0);
        check(pw_we_o == 1'b0, "R8 reset posted enable", pw_we_o, 0);
        for (int i = 0; i < 8; i++) begin
            peek_addr_i = 3'(i);
            #0.1;
            check(peek_data_o == 16'd0, "R8 reset register", peek_data_o, 0);
        end
        @(posedge clk);
        #1;
        rst = 1'b0;
        run = 1'b1;
        wait (done);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            peek_addr_i = 3'(i);
            #0.1;
            check(peek_data_o == mreg[i], (i == 0) ? "R6 register zero" : "R3 final register",
                  peek_data_o, mreg[i]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nfetch, 140);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule